// File: doc/BRIEF.md
# Two-Read One-Write Register RAM

This block is a small storage array of 64 words of 18 bits (1,152 bits) with one clocked write port and two read ports, A and B, that work independently of each other. It is meant to hold the contents of small FIFOs or coefficient tables, with the FIFO pointer logic and any error correction kept outside it.

Each read port works in one of two ways. In combinational mode the port returns the stored word at its address within the same cycle. In registered mode the word is captured into an output register on the rising edge, under a read enable. The mode of each port is either fixed by a parameter or taken from a mode pin, and this choice is a parameter too. Each read port has its own synchronous reset that clears only that port's output register.

Top module: `trireg_ram`

## Requirements
- R1: A rising edge with `wr_en` high stores `wr_data` into word `wr_addr`; all 64 addresses (0 to 63) hold 18-bit values independently.
- R2: A rising edge with `wr_en` low leaves every stored word unchanged.
- R3: With a port's mode at 0 (combinational), its read data equals the word at its read address in the same cycle, with no clock edge needed.
- R4: With a port's mode at 1 (registered) and its enable high, the rising edge loads the word at its read address into the port output.
- R5: In registered mode, an edge with the enable low holds the port output at its previous value.
- R6: In registered mode, a read of the address being written on the same edge returns the word held before that write.
- R7: In combinational mode, a read of the address written on an edge returns the new word right after that edge.
- R8: A port reset high on an edge clears that port's output register to 0, takes priority over the enable, and leaves the stored words and the other port unchanged.
- R9: Ports A and B read different addresses, in different modes, in the same cycle without affecting each other.
- R10: When a port takes its mode from its pin, changing the pin switches the output between the stored word and the register contents within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes and register loads on the rising edge |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 6 | Write address |
| wr_data | input | 18 | Write data |
| a_en | input | 1 | Port A read enable (registered mode) |
| a_rst | input | 1 | Port A synchronous output-register reset |
| a_mode | input | 1 | Port A mode pin: 0 combinational, 1 registered |
| a_addr | input | 6 | Port A read address |
| a_data | output | 18 | Port A read data |
| b_en | input | 1 | Port B read enable (registered mode) |
| b_rst | input | 1 | Port B synchronous output-register reset |
| b_mode | input | 1 | Port B mode pin: 0 combinational, 1 registered |
| b_addr | input | 6 | Port B read address |
| b_data | output | 18 | Port B read data |

## Verification
The write and a read of the same word can fall on one edge, and the answer depends on the read mode. The bench points port A (combinational) and port B (registered) at the address being written in the same cycle, then checks that B captured the word from before the edge while A shows the new word straight after it. A port reset coinciding with a high enable is provoked the same way and judged by a zero output followed by an intact reload.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int WORD_W_DEF = 18;
    localparam int DEPTH_DEF  = 64;
    localparam int N_RD       = 2;

    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REG  = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic en;
        logic rst;
        logic mode_pin;
    } rd_ctl_t;

    function automatic rd_mode_e pick_mode(input bit use_pin, input logic pin,
                                           input rd_mode_e fixed);
        if (use_pin) return rd_mode_e'(pin);
        return fixed;
    endfunction

endpackage

// File: rtl/tpr_array.sv
module tpr_array #(
    parameter int W     = 18,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int NRD   = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = mem[raddr[i]];
    end
endmodule

// File: rtl/tpr_rd_port.sv
module tpr_rd_port
    import tpr_pkg::*;
#(
    parameter int       W       = 18,
    parameter bit       USE_PIN = 1'b1,
    parameter rd_mode_e FIXED   = RD_REG
) (
    input  logic         clk,
    input  rd_ctl_t      ctl,
    input  logic [W-1:0] raw,
    output logic [W-1:0] data,
    output logic         mode_o
);
    rd_mode_e     mode;
    logic [W-1:0] q;

    assign mode   = pick_mode(USE_PIN, ctl.mode_pin, FIXED);
    assign mode_o = (mode == RD_REG);

    always_ff @(posedge clk) begin
        if (ctl.rst)     q <= '0;
        else if (ctl.en) q <= raw;
    end

    assign data = (mode == RD_REG) ? q : raw;
endmodule

// File: rtl/trireg_ram.sv
module trireg_ram
    import tpr_pkg::*;
#(
    parameter int       WORD_W       = WORD_W_DEF,
    parameter int       DEPTH        = DEPTH_DEF,
    parameter bit       A_MODE_PIN   = 1'b1,
    parameter rd_mode_e A_MODE_FIXED = RD_REG,
    parameter bit       B_MODE_PIN   = 1'b1,
    parameter rd_mode_e B_MODE_FIXED = RD_REG
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     a_en,
    input  logic                     a_rst,
    input  logic                     a_mode,
    input  logic [$clog2(DEPTH)-1:0] a_addr,
    output logic [WORD_W-1:0]        a_data,
    input  logic                     b_en,
    input  logic                     b_rst,
    input  logic                     b_mode,
    input  logic [$clog2(DEPTH)-1:0] b_addr,
    output logic [WORD_W-1:0]        b_data
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam bit [N_RD-1:0] USE_PIN = {B_MODE_PIN, A_MODE_PIN};
    localparam rd_mode_e FIXED [N_RD] = '{A_MODE_FIXED, B_MODE_FIXED};

    logic    [N_RD-1:0][ADDR_W-1:0] raddr;
    logic    [N_RD-1:0][WORD_W-1:0] raw;
    logic    [N_RD-1:0][WORD_W-1:0] rout;
    logic    [N_RD-1:0]             mode_eff;
    rd_ctl_t                        ctl [N_RD];

    assign raddr[0] = a_addr;
    assign raddr[1] = b_addr;
    assign ctl[0]   = '{en: a_en, rst: a_rst, mode_pin: a_mode};
    assign ctl[1]   = '{en: b_en, rst: b_rst, mode_pin: b_mode};

    tpr_array #(.W(WORD_W), .DEPTH(DEPTH), .AW(ADDR_W), .NRD(N_RD)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (raw)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        tpr_rd_port #(.W(WORD_W), .USE_PIN(USE_PIN[p]), .FIXED(FIXED[p])) u_port (
            .clk    (clk),
            .ctl    (ctl[p]),
            .raw    (raw[p]),
            .data   (rout[p]),
            .mode_o (mode_eff[p])
        );
    end

    assign a_data = rout[0];
    assign b_data = rout[1];
endmodule

// File: rtl/tpr_chk.sv
module tpr_chk #(
    parameter int W  = 18,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic          a_en,
    input logic          a_rst,
    input logic [AW-1:0] a_addr,
    input logic [W-1:0]  a_data,
    input logic          a_reg,
    input logic [W-1:0]  a_raw,
    input logic          b_en,
    input logic          b_rst,
    input logic [W-1:0]  b_data,
    input logic          b_reg,
    input logic [W-1:0]  b_raw
);
    AST_A_RST_CLEARS: assert property (@(posedge clk)
        a_rst |=> (!a_reg || a_data == '0)); // R8
    AST_B_RST_CLEARS: assert property (@(posedge clk)
        b_rst |=> (!b_reg || b_data == '0)); // R8
    AST_A_HOLD_NO_EN: assert property (@(posedge clk) disable iff (a_rst)
        (a_reg && !a_en) |=> (!a_reg || a_rst || $stable(a_data))); // R5
    AST_B_HOLD_NO_EN: assert property (@(posedge clk) disable iff (b_rst)
        (b_reg && !b_en) |=> (!b_reg || b_rst || $stable(b_data))); // R5
    AST_A_OLD_ON_RDW: assert property (@(posedge clk) disable iff (a_rst)
        (a_reg && a_en) |=> (!a_reg || a_data == $past(a_raw))); // R6
    AST_B_OLD_ON_RDW: assert property (@(posedge clk) disable iff (b_rst)
        (b_reg && b_en) |=> (!b_reg || b_data == $past(b_raw))); // R6
    AST_A_COMB_NEW: assert property (@(posedge clk) disable iff (a_rst)
        wr_en |=> (a_reg || a_addr != $past(wr_addr) || a_data == $past(wr_data))); // R7
endmodule

bind trireg_ram tpr_chk #(.W(WORD_W), .AW(ADDR_W)) u_chk (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .a_en    (a_en),
    .a_rst   (a_rst),
    .a_addr  (a_addr),
    .a_data  (a_data),
    .a_reg   (mode_eff[0]),
    .a_raw   (raw[0]),
    .b_en    (b_en),
    .b_rst   (b_rst),
    .b_data  (b_data),
    .b_reg   (mode_eff[1]),
    .b_raw   (raw[1])
);

// File: tb/sim_trireg_ram.sv
`timescale 1ns/1ps
module sim_trireg_ram;
    localparam int W  = 18;
    localparam int AW = 6;
    localparam int NV = 8;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [W-1:0]  data;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{6'd0,  18'h3FFFF}, '{6'd63, 18'h00001}, '{6'd1,  18'h2AAAA},
        '{6'd62, 18'h15555}, '{6'd31, 18'h0F0F0}, '{6'd32, 18'h30F0F},
        '{6'd17, 18'h00000}, '{6'd45, 18'h20001}
    };

    logic          clk = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          a_en = 1'b0, a_rst = 1'b0, a_mode = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic [W-1:0]  a_data;
    logic          b_en = 1'b0, b_rst = 1'b0, b_mode = 1'b1;
    logic [AW-1:0] b_addr = '0;
    logic [W-1:0]  b_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trireg_ram u0 (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .a_en(a_en), .a_rst(a_rst), .a_mode(a_mode), .a_addr(a_addr), .a_data(a_data),
        .b_en(b_en), .b_rst(b_rst), .b_mode(b_mode), .b_addr(b_addr), .b_data(b_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %05h expected %05h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        // R8: reset state of both output registers
        a_mode = 1'b1; b_mode = 1'b1; a_rst = 1'b1; b_rst = 1'b1;
        tick();
        chk("R8 reset A", a_data, '0);
        chk("R8 reset B", b_data, '0);
        a_rst = 1'b0; b_rst = 1'b0; a_mode = 1'b0;

        // R1: fill from the vector table
        for (int i = 0; i < NV; i++) begin
            wr_en = 1'b1; wr_addr = VEC[i].addr; wr_data = VEC[i].data;
            tick();
        end
        wr_en = 1'b0;

        // R1 R3 R4: read every vector back, A combinational, B registered
        b_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            a_addr = VEC[i].addr; b_addr = VEC[i].addr;
            #1;
            chk("R3 comb read A", a_data, VEC[i].data);
            tick();
            chk("R4 R1 reg read B", b_data, VEC[i].data);
        end

        // R2: write enable low changes nothing
        wr_en = 1'b0; wr_addr = 6'd0; wr_data = 18'h00000; a_addr = 6'd0;
        tick();
        #1;
        chk("R2 no write", a_data, 18'h3FFFF);

        // R5: enable low holds registered output
        b_addr = 6'd31; tick();
        chk("R4 load 31", b_data, 18'h0F0F0);
        b_en = 1'b0; b_addr = 6'd63;
        tick(); tick();
        chk("R5 hold", b_data, 18'h0F0F0);

        // R6 R7: read and write of one word on the same edge
        b_en = 1'b1; b_addr = 6'd1; a_addr = 6'd1;
        wr_en = 1'b1; wr_addr = 6'd1; wr_data = 18'h12345;
        #1;
        chk("R7 before edge A", a_data, 18'h2AAAA);
        tick();
        wr_en = 1'b0;
        chk("R6 old data B", b_data, 18'h2AAAA);
        chk("R7 new data A", a_data, 18'h12345);
        tick();
        chk("R6 next load B", b_data, 18'h12345);

        // R8: reset beats enable, memory kept
        b_rst = 1'b1; b_en = 1'b1;
        tick();
        chk("R8 rst over en B", b_data, '0);
        chk("R8 memory kept", a_data, 18'h12345);
        b_rst = 1'b0;
        tick();
        chk("R8 reload B", b_data, 18'h12345);

        // R9: modes swapped, different addresses, independent reset
        a_mode = 1'b1; a_en = 1'b1; a_addr = 6'd63; b_mode = 1'b0; b_addr = 6'd0;
        tick();
        chk("R9 A reg", a_data, 18'h00001);
        chk("R9 B comb", b_data, 18'h3FFFF);
        b_mode = 1'b1; b_en = 1'b1; b_addr = 6'd62;
        tick();
        b_en = 1'b0;
        held = b_data;
        chk("R9 B load", held, 18'h15555);
        a_rst = 1'b1;
        tick();
        a_rst = 1'b0;
        chk("R9 A reset", a_data, '0);
        chk("R9 B untouched by A reset", b_data, 18'h15555);

        // R10: mode pin switches output in the same cycle
        b_addr = 6'd45;
        #1;
        chk("R10 reg view", b_data, 18'h15555);
        b_mode = 1'b0;
        #1;
        chk("R10 comb view", b_data, 18'h20001);
        b_mode = 1'b1;
        #1;
        chk("R10 back to reg", b_data, 18'h15555);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule